// File: doc/BRIEF.md
# Host Command Framing Controller

This controller sits behind a SPI target whose output side is a small circular byte buffer that the host clocks back blindly on every transfer. It takes the bytes the host sends and collects one request into a local request memory. The request starts with an 8-byte header, and the header's first byte names the protocol version. Once the whole request is in, the controller hands it to a local command handler with a valid/ready handshake.

While the request is being received, while the handler works, and after errors, the controller keeps the output buffer full of one-byte status codes. A host that polls for a reply therefore always reads a meaningful byte. When the handler finishes, the response goes into the output buffer a fixed preamble distance ahead of the host's live read pointer. The response is a frame-start marker, then the payload, then a trailing past-end marker. The output buffer is refilled one half at a time as the host pointer moves on.

The controller also handles three fault cases. If chip select is released during processing, the pending response is cancelled. A receive that runs too long times out. A malformed header is rejected.

Top module: `host_frame_ctrl`

## Requirements
- R1: After reset the controller is disabled, `reqValid` is low, output byte 0 holds old-ready (0xFD) and every other output byte holds receiving (0xF8).
- R2: While `enable` is low the controller stays disabled and ignores chip select and received bytes. Raising `enable` moves it to ready and rewrites the pattern of R1.
- R3: In ready, asserting chip select starts a receive. If the first received byte is not 3, the whole output buffer becomes bad-data (0xFB) until chip select is released.
- R4: The request length is 8 plus the little-endian 16-bit value in header bytes 6 (low) and 7 (high). A length above 544 (MAX_REQ) fills the buffer with bad-data right after byte 7. A length of exactly 544 is accepted.
- R5: After the last request byte, every output byte becomes processing (0xFA), `reqValid` rises, `reqLen` shows the length, and byte i of the request reads back at `reqRdAddr` = i.
- R6: On `respReady` in processing, the response stream is written starting at output index (hostPtr + 2) mod 64. Stream byte 0 is frame-start (0xEC), bytes 1..L are payload bytes 0..L-1 read through `respAddr`/`respData`, and byte L+1 is past-end (0xED). The first fill runs to the next half boundary (32 or 64) plus one further half of 32 bytes, or to the end of the stream if that comes first.
- R7: While sending, `halfEvt` refills output indices 0..31 with the next stream bytes only when the write head sits at index 0. `fullEvt` refills indices 32..63 only when the write head sits at index 32. Any other event leaves the buffer unchanged.
- R8: If chip select is released during processing, every output byte becomes not-ready (0xFC). A new chip-select assertion leaves the buffer unchanged. The following `respReady` restores the ready pattern of R1 and writes no response.
- R9: If a request is not complete RX_TIMEOUT ticks of `usTick` after chip select was asserted, every output byte becomes bad-data.
- R10: Releasing chip select while receiving, sending or in bad-data returns the controller to ready with the pattern of R1.
- R11: A zero-length response still produces frame-start followed directly by past-end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enabled |
| csActive | input | 1 | Chip select asserted (level) |
| rxValid | input | 1 | One received byte is present this cycle |
| rxData | input | 8 | Received byte |
| hostPtr | input | 6 | Host's live output buffer index |
| halfEvt | input | 1 | Host pointer reached the buffer midpoint |
| fullEvt | input | 1 | Host pointer wrapped to index 0 |
| obufData | output | 8 | Output buffer byte at hostPtr |
| usTick | input | 1 | One-microsecond timer tick |
| reqValid | output | 1 | Complete request waits for the handler |
| reqLen | output | 10 | Request length in bytes |
| reqRdAddr | input | 10 | Handler's request read address |
| reqRdData | output | 8 | Request byte at reqRdAddr |
| respReady | input | 1 | Handler's response is ready (pulse) |
| respLen | input | 10 | Response payload length |
| respAddr | output | 10 | Payload index being fetched |
| respData | input | 8 | Payload byte at respAddr |

## Verification
The assertions check, on every cycle, that a low enable forces the disabled state and that a release of chip select during processing always lands in the cancelled state. They also check that a wrong version byte always leads to bad-data, that the three buffer-wide fill strobes are never raised together, and that the response writer never moves past the end of its stream. Only the directed scenarios can show which bytes end up at which output indices: the preamble offset, the split of the first fill at a half boundary, the refills that are taken or ignored, the 544-byte boundary, the timeout and the zero-length frame.

// File: rtl/hcf_pkg.sv
package hcf_pkg;

  typedef enum logic [2:0] {
    ST_DISABLED,
    ST_READY,
    ST_RECV,
    ST_PROC,
    ST_CANCEL,
    ST_SEND,
    ST_BAD
  } hcfState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       fillReady;   // rewrite idle pattern
    logic       fillAll;     // flood buffer with fillCode
    logic [7:0] fillCode;
    logic       respStart;   // begin response stream
    logic       refillLo;    // host reached midpoint
    logic       refillHi;    // host wrapped to zero
    logic       reqWr;       // store received byte
  } hcfStrobes_t;

endpackage

// File: rtl/hcf_ctrl.sv
module hcf_ctrl
  import hcf_pkg::*;
#(
  parameter int MAX_REQ    = 544,
  parameter int RX_TIMEOUT = 8192,
  parameter int LEN_W      = 10,
  parameter logic [7:0] CODE_PROC = 8'hFA,
  parameter logic [7:0] CODE_BAD  = 8'hFB,
  parameter logic [7:0] CODE_NRDY = 8'hFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             csActive,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             usTick,
  input  logic             halfEvt,
  input  logic             fullEvt,
  input  logic             respReady,
  output hcfStrobes_t      str,
  output logic [LEN_W-1:0] reqAddr,
  output logic             reqValid,
  output logic [LEN_W-1:0] reqLen
);

  localparam int TMR_W = $clog2(RX_TIMEOUT + 1);
  localparam logic [7:0] VERSION = 8'd3;
  localparam int HDR_LEN = 8;

  hcfState_t        state, stNext;
  logic             csPrev;
  logic [LEN_W-1:0] rxCnt;
  logic [LEN_W-1:0] totalLen;
  logic [7:0]       lenLo;
  logic [TMR_W-1:0] tmr;
  logic [16:0]      hdrTotal;
  logic             csRise, csAssert, timeoutHit;

  assign csRise     = csPrev && !csActive;
  assign csAssert   = !csPrev && csActive;
  assign timeoutHit = usTick && (tmr == TMR_W'(RX_TIMEOUT - 1));
  assign hdrTotal   = 17'(HDR_LEN) + {1'b0, rxData, lenLo};

  always_comb begin
    stNext = state;
    str    = '0;
    case (state)
      ST_DISABLED: if (enable) begin
        stNext = ST_READY;
        str.fillReady = 1'b1;
      end
      ST_READY: if (csAssert) stNext = ST_RECV;
      ST_RECV: begin
        if (csRise) begin
          stNext = ST_READY;
          str.fillReady = 1'b1;
        end else if (timeoutHit) begin
          stNext = ST_BAD;
          str.fillAll = 1'b1;
          str.fillCode = CODE_BAD;
        end else if (rxValid) begin
          str.reqWr = 1'b1;
          if (rxCnt == '0 && rxData != VERSION) begin
            stNext = ST_BAD;
            str.fillAll = 1'b1;
            str.fillCode = CODE_BAD;
          end else if (rxCnt == LEN_W'(HDR_LEN - 1)) begin
            if (hdrTotal > 17'(MAX_REQ)) begin
              stNext = ST_BAD;
              str.fillAll = 1'b1;
              str.fillCode = CODE_BAD;
            end else if (hdrTotal == 17'(HDR_LEN)) begin
              stNext = ST_PROC;
              str.fillAll = 1'b1;
              str.fillCode = CODE_PROC;
            end
          end else if (rxCnt > LEN_W'(HDR_LEN - 1) && LEN_W'(rxCnt + 1'b1) == totalLen) begin
            stNext = ST_PROC;
            str.fillAll = 1'b1;
            str.fillCode = CODE_PROC;
          end
        end
      end
      ST_PROC: begin
        if (csRise) begin
          stNext = ST_CANCEL;
          str.fillAll = 1'b1;
          str.fillCode = CODE_NRDY;
        end else if (respReady) begin
          stNext = ST_SEND;
          str.respStart = 1'b1;
        end
      end
      ST_CANCEL: if (respReady) begin
        stNext = ST_READY;
        str.fillReady = 1'b1;
      end
      ST_SEND: begin
        if (csRise) begin
          stNext = ST_READY;
          str.fillReady = 1'b1;
        end else begin
          str.refillLo = halfEvt;
          str.refillHi = fullEvt;
        end
      end
      ST_BAD: if (csRise) begin
        stNext = ST_READY;
        str.fillReady = 1'b1;
      end
      default: stNext = ST_DISABLED;
    endcase
    if (!enable) begin
      stNext = ST_DISABLED;
      str    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_DISABLED;
      csPrev   <= 1'b0;
      rxCnt    <= '0;
      tmr      <= '0;
      lenLo    <= '0;
      totalLen <= '0;
    end else begin
      state  <= stNext;
      csPrev <= csActive;
      if (state == ST_READY) begin
        rxCnt <= '0;
        tmr   <= '0;
      end else if (state == ST_RECV) begin
        if (rxValid) rxCnt <= rxCnt + 1'b1;
        if (usTick) tmr <= tmr + 1'b1;
        if (rxValid && rxCnt == LEN_W'(HDR_LEN - 2)) lenLo <= rxData;
        if (rxValid && rxCnt == LEN_W'(HDR_LEN - 1)) totalLen <= hdrTotal[LEN_W-1:0];
      end
    end
  end

  assign reqAddr  = rxCnt;
  assign reqValid = (state == ST_PROC);
  assign reqLen   = totalLen;

  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> state == ST_DISABLED); // R2

  AST_CANCEL_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_PROC && csRise) |=> state == ST_CANCEL); // R8

  AST_BAD_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_RECV && !csRise && !timeoutHit && rxValid
     && rxCnt == '0 && rxData != VERSION) |=> state == ST_BAD); // R3

endmodule

// File: rtl/hcf_data.sv
module hcf_data
  import hcf_pkg::*;
#(
  parameter int OBUF_DEPTH = 64,
  parameter int MAX_REQ    = 544,
  parameter int PREAMBLE   = 2,
  parameter int LEN_W      = 10,
  parameter int PTR_W      = 6,
  parameter logic [7:0] CODE_FRAME = 8'hEC,
  parameter logic [7:0] CODE_PAST  = 8'hED,
  parameter logic [7:0] CODE_RECV  = 8'hF8,
  parameter logic [7:0] CODE_OLD   = 8'hFD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hcfStrobes_t      str,
  input  logic [LEN_W-1:0] reqAddr,
  input  logic [7:0]       rxData,
  input  logic [PTR_W-1:0] hostPtr,
  output logic [7:0]       obufData,
  input  logic [LEN_W-1:0] reqRdAddr,
  output logic [7:0]       reqRdData,
  input  logic [LEN_W-1:0] respLen,
  output logic [LEN_W-1:0] respAddr,
  input  logic [7:0]       respData
);

  localparam int HALF = OBUF_DEPTH / 2;
  localparam logic [PTR_W-1:0] HALF_IDX = PTR_W'(HALF);

  logic [7:0] obuf   [OBUF_DEPTH];
  logic [7:0] reqMem [MAX_REQ];

  logic             busy;
  logic [PTR_W-1:0] wrPos;
  logic [LEN_W-1:0] sendIdx, sendTotal, chunkLeft;
  logic [PTR_W-1:0] startOff;
  logic [LEN_W-1:0] firstSpan, newTotal, firstLen, remain, halfLen;
  logic [7:0]       streamByte;
  logic             moreToSend;

  assign startOff  = hostPtr + PTR_W'(PREAMBLE);
  assign firstSpan = LEN_W'(OBUF_DEPTH) - LEN_W'(startOff[PTR_W-2:0]);
  assign newTotal  = respLen + LEN_W'(2);
  assign firstLen  = (firstSpan < newTotal) ? firstSpan : newTotal;
  assign remain    = sendTotal - sendIdx;
  assign halfLen   = (remain < LEN_W'(HALF)) ? remain : LEN_W'(HALF);
  assign moreToSend = !busy && (sendIdx < sendTotal);

  assign respAddr   = sendIdx - 1'b1;
  assign streamByte = (sendIdx == '0) ? CODE_FRAME :
                      (sendIdx == sendTotal - 1'b1) ? CODE_PAST : respData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < OBUF_DEPTH; i++) obuf[i] <= (i == 0) ? CODE_OLD : CODE_RECV;
      busy      <= 1'b0;
      wrPos     <= '0;
      sendIdx   <= '0;
      sendTotal <= '0;
      chunkLeft <= '0;
    end else if (str.fillReady) begin
      for (int i = 0; i < OBUF_DEPTH; i++) obuf[i] <= (i == 0) ? CODE_OLD : CODE_RECV;
      busy      <= 1'b0;
      sendIdx   <= '0;
      sendTotal <= '0;
    end else if (str.fillAll) begin
      for (int i = 0; i < OBUF_DEPTH; i++) obuf[i] <= str.fillCode;
      busy      <= 1'b0;
      sendIdx   <= '0;
      sendTotal <= '0;
    end else if (str.respStart) begin
      busy      <= 1'b1;
      wrPos     <= startOff;
      sendIdx   <= '0;
      sendTotal <= newTotal;
      chunkLeft <= firstLen;
    end else if (busy) begin
      obuf[wrPos] <= streamByte;
      wrPos       <= wrPos + 1'b1;
      sendIdx     <= sendIdx + 1'b1;
      chunkLeft   <= chunkLeft - 1'b1;
      busy        <= (chunkLeft != LEN_W'(1));
    end else if (moreToSend && ((str.refillLo && wrPos == '0) ||
                                (str.refillHi && wrPos == HALF_IDX))) begin
      busy      <= 1'b1;
      chunkLeft <= halfLen;
    end
  end

  always_ff @(posedge clk) begin
    if (str.reqWr && reqAddr < LEN_W'(MAX_REQ)) reqMem[reqAddr] <= rxData;
  end

  assign obufData  = obuf[hostPtr];
  assign reqRdData = (reqRdAddr < LEN_W'(MAX_REQ)) ? reqMem[reqRdAddr] : 8'h00;

  AST_FILL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({str.fillReady, str.fillAll, str.respStart})); // R6

  AST_STREAM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> sendIdx < sendTotal); // R7

endmodule

// File: rtl/host_frame_ctrl.sv
module host_frame_ctrl
  import hcf_pkg::*;
#(
  parameter int OBUF_DEPTH = 64,
  parameter int MAX_REQ    = 544,
  parameter int RX_TIMEOUT = 8192,
  parameter int PREAMBLE   = 2,
  parameter logic [7:0] CODE_FRAME = 8'hEC,
  parameter logic [7:0] CODE_PAST  = 8'hED,
  parameter logic [7:0] CODE_RECV  = 8'hF8,
  parameter logic [7:0] CODE_PROC  = 8'hFA,
  parameter logic [7:0] CODE_BAD   = 8'hFB,
  parameter logic [7:0] CODE_NRDY  = 8'hFC,
  parameter logic [7:0] CODE_OLD   = 8'hFD,
  localparam int PTR_W = $clog2(OBUF_DEPTH),
  localparam int LEN_W = $clog2(MAX_REQ + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             csActive,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic [PTR_W-1:0] hostPtr,
  input  logic             halfEvt,
  input  logic             fullEvt,
  output logic [7:0]       obufData,
  input  logic             usTick,
  output logic             reqValid,
  output logic [LEN_W-1:0] reqLen,
  input  logic [LEN_W-1:0] reqRdAddr,
  output logic [7:0]       reqRdData,
  input  logic             respReady,
  input  logic [LEN_W-1:0] respLen,
  output logic [LEN_W-1:0] respAddr,
  input  logic [7:0]       respData
);

  hcfStrobes_t      str;
  logic [LEN_W-1:0] reqAddr;

  hcf_ctrl #(
    .MAX_REQ(MAX_REQ), .RX_TIMEOUT(RX_TIMEOUT), .LEN_W(LEN_W),
    .CODE_PROC(CODE_PROC), .CODE_BAD(CODE_BAD), .CODE_NRDY(CODE_NRDY)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .csActive(csActive),
    .rxValid(rxValid), .rxData(rxData), .usTick(usTick),
    .halfEvt(halfEvt), .fullEvt(fullEvt), .respReady(respReady),
    .str(str), .reqAddr(reqAddr), .reqValid(reqValid), .reqLen(reqLen)
  );

  hcf_data #(
    .OBUF_DEPTH(OBUF_DEPTH), .MAX_REQ(MAX_REQ), .PREAMBLE(PREAMBLE),
    .LEN_W(LEN_W), .PTR_W(PTR_W),
    .CODE_FRAME(CODE_FRAME), .CODE_PAST(CODE_PAST),
    .CODE_RECV(CODE_RECV), .CODE_OLD(CODE_OLD)
  ) i_data (
    .clk(clk), .rst_n(rst_n), .str(str), .reqAddr(reqAddr), .rxData(rxData),
    .hostPtr(hostPtr), .obufData(obufData),
    .reqRdAddr(reqRdAddr), .reqRdData(reqRdData),
    .respLen(respLen), .respAddr(respAddr), .respData(respData)
  );

endmodule

// File: tb/test_host_frame_ctrl.sv
module test_host_frame_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       csActive = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic [5:0] hostPtr = 6'd0;
  logic       halfEvt = 1'b0;
  logic       fullEvt = 1'b0;
  logic [7:0] obufData;
  logic       usTick = 1'b0;
  logic       reqValid;
  logic [9:0] reqLen;
  logic [9:0] reqRdAddr = 10'd0;
  logic [7:0] reqRdData;
  logic       respReady = 1'b0;
  logic [9:0] respLen = 10'd0;
  logic [9:0] respAddr;
  logic [7:0] respData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [7:0] payload(input logic [9:0] i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  assign respData = payload(respAddr);

  host_frame_ctrl i_host_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .csActive(csActive),
    .rxValid(rxValid), .rxData(rxData), .hostPtr(hostPtr),
    .halfEvt(halfEvt), .fullEvt(fullEvt), .obufData(obufData),
    .usTick(usTick), .reqValid(reqValid), .reqLen(reqLen),
    .reqRdAddr(reqRdAddr), .reqRdData(reqRdData),
    .respReady(respReady), .respLen(respLen),
    .respAddr(respAddr), .respData(respData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic peek(input int pos, output logic [7:0] v);
    hostPtr = 6'(pos);
    #1;
    v = obufData;
  endtask

  task automatic chkBuf(input string tag, input int pos, input int expected);
    logic [7:0] v;
    peek(pos, v);
    chk(tag, int'(v), expected);
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1;
    rxData  = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic csOn;
    @(negedge clk);
    csActive = 1'b1;
    idle(2);
  endtask

  task automatic csOff;
    @(negedge clk);
    csActive = 1'b0;
    idle(2);
  endtask

  task automatic sendReq(input int dataLen);
    sendByte(8'd3);
    sendByte(8'h5C);
    sendByte(8'h21);
    sendByte(8'h00);
    sendByte(8'h00);
    sendByte(8'h00);
    sendByte(8'(dataLen & 8'hFF));
    sendByte(8'(dataLen >> 8));
    for (int i = 0; i < dataLen; i++) sendByte(8'(i ^ 8'h33));
    idle(2);
  endtask

  task automatic respond(input int len, input int ptr, input int waitCycles);
    @(negedge clk);
    hostPtr   = 6'(ptr);
    respLen   = 10'(len);
    respReady = 1'b1;
    @(negedge clk);
    respReady = 1'b0;
    idle(waitCycles);
  endtask

  task automatic pulse(input bit hi);
    @(negedge clk);
    if (hi) fullEvt = 1'b1; else halfEvt = 1'b1;
    @(negedge clk);
    fullEvt = 1'b0;
    halfEvt = 1'b0;
    idle(40);
  endtask

  task automatic chkReady(input string tag);
    chkBuf(tag, 0, 8'hFD);
    chkBuf(tag, 1, 8'hF8);
    chkBuf(tag, 63, 8'hF8);
  endtask

  task automatic testReset;
    chk("R1 reqValid", int'(reqValid), 0);
    chkReady("R1 idle pattern");
  endtask

  task automatic testDisabled;
    csOn();
    sendByte(8'h02);
    csOff();
    chkReady("R2 disabled ignores");
    chk("R2 reqValid disabled", int'(reqValid), 0);
    @(negedge clk);
    enable = 1'b1;
    idle(2);
    chkReady("R2 enabled ready");
  endtask

  task automatic testBasic;
    csOn();
    sendReq(4);
    chkBuf("R5 proc fill 0", 0, 8'hFA);
    chkBuf("R5 proc fill 63", 63, 8'hFA);
    chk("R5 reqValid", int'(reqValid), 1);
    chk("R5 reqLen", int'(reqLen), 12);
    reqRdAddr = 10'd9;
    #1;
    chk("R5 request byte", int'(reqRdData), 1 ^ 8'h33);
    reqRdAddr = 10'd0;
    #1;
    chk("R5 version byte", int'(reqRdData), 3);
    respond(40, 20, 60);
    chkBuf("R6 frame start", 22, 8'hEC);
    chkBuf("R6 payload", 30, int'(payload(10'd7)));
    chkBuf("R6 past end", 63, 8'hED);
    chkBuf("R6 untouched before", 21, 8'hFA);
    csOff();
    chkReady("R10 release while sending");
  endtask

  task automatic testRefill;
    csOn();
    sendReq(0);
    respond(100, 40, 80);
    chkBuf("R6 wrap frame start", 42, 8'hEC);
    chkBuf("R6 wrap tail", 63, int'(payload(10'd20)));
    chkBuf("R6 wrap head", 0, int'(payload(10'd21)));
    chkBuf("R6 second half end", 31, int'(payload(10'd52)));
    chkBuf("R6 stops at half", 32, 8'hFA);
    pulse(1'b0);
    chkBuf("R7 half event ignored", 32, 8'hFA);
    pulse(1'b1);
    chkBuf("R7 upper refill start", 32, int'(payload(10'd53)));
    chkBuf("R7 upper refill end", 63, int'(payload(10'd84)));
    pulse(1'b0);
    chkBuf("R7 lower refill", 0, int'(payload(10'd85)));
    chkBuf("R7 last payload", 14, int'(payload(10'd99)));
    chkBuf("R7 past end", 15, 8'hED);
    chkBuf("R7 beyond stream", 16, int'(payload(10'd37)));
    csOff();
    chkReady("R10 ready after refill");
  endtask

  task automatic testZeroLen;
    csOn();
    sendReq(0);
    chk("R4 zero data length", int'(reqLen), 8);
    respond(0, 0, 20);
    chkBuf("R11 frame start", 2, 8'hEC);
    chkBuf("R11 past end", 3, 8'hED);
    chkBuf("R11 nothing more", 4, 8'hFA);
    csOff();
  endtask

  task automatic testCancel;
    csOn();
    sendReq(2);
    csOff();
    chkBuf("R8 not ready 0", 0, 8'hFC);
    chkBuf("R8 not ready 40", 40, 8'hFC);
    chk("R8 reqValid low", int'(reqValid), 0);
    csOn();
    chkBuf("R8 assert ignored", 1, 8'hFC);
    csOff();
    respond(10, 0, 30);
    chkReady("R8 response discarded");
  endtask

  task automatic testBadVersion;
    csOn();
    sendByte(8'h02);
    idle(2);
    chkBuf("R3 bad data 0", 0, 8'hFB);
    chkBuf("R3 bad data 50", 50, 8'hFB);
    csOff();
    chkReady("R10 release from bad");
  endtask

  task automatic testLength;
    csOn();
    sendByte(8'd3);
    for (int i = 0; i < 5; i++) sendByte(8'h00);
    sendByte(8'h19);
    sendByte(8'h02);
    idle(2);
    chkBuf("R4 over limit", 7, 8'hFB);
    csOff();
    csOn();
    sendReq(536);
    chk("R4 boundary accepted", int'(reqValid), 1);
    chk("R4 boundary length", int'(reqLen), 544);
    reqRdAddr = 10'd543;
    #1;
    chk("R5 last request byte", int'(reqRdData), int'(8'(535 ^ 8'h33)));
    csOff();
    respond(1, 0, 10);
    chkReady("R8 ready after boundary");
  endtask

  task automatic testTimeout;
    csOn();
    sendByte(8'd3);
    @(negedge clk);
    usTick = 1'b1;
    idle(8000);
    chkBuf("R9 still receiving", 1, 8'hF8);
    idle(300);
    chkBuf("R9 timed out", 1, 8'hFB);
    usTick = 1'b0;
    csOff();
    chkReady("R10 ready after timeout");
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    testReset();
    testDisabled();
    testBasic();
    testRefill();
    testZeroLen();
    testCancel();
    testBadVersion();
    testLength();
    testTimeout();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule